// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the timer that sits beside a local interrupt controller. Software programs three registers: a divide setting that picks how many input clocks make one count step, a timer entry that holds the interrupt vector, a mask bit and a mode bit, and an initial count. After the initial count is written the block counts down once per divided tick. The live count can be read back at any time.

In one-shot mode the count falls to zero and stays there. On the tick after it reaches zero the timer expires once. In periodic mode the count reloads from the initial value on the tick after it reaches zero, so each period spans the initial count plus one ticks. Each expiry with the timer unmasked gives a one-cycle interrupt request together with the 8-bit vector. Delivery and priority handling belong to the logic that receives the request.

Top module: `lvt_countdown_timer`

## Requirements
- R1: After reset the divide register (address 0) reads 0, the timer entry (address 1) reads 0x00010000, the initial count (address 2) and current count (address 3) read 0, and irq_req and irq_vector are 0.
- R2: A divide write keeps only bits 3, 1 and 0 of the data, and address 0 reads back that masked value. The code {bit3, bit1, bit0} gives the shift (code + 1) mod 8, and one count step takes 2^shift clocks: code 7 steps every clock, code 0 every 2 clocks, code 3 every 16 clocks and code 4 every 32 clocks.
- R3: In one-shot mode (entry bit 17 = 0), with D divided ticks since the load, the current count reads max(W − D, 0) for an initial count W.
- R4: A one-shot timer with W > 0 expires exactly once per initial-count write, on tick W + 1.
- R5: In periodic mode (entry bit 17 = 1) the current count reads W − (D mod (W + 1)). It expires on every tick where D is a nonzero multiple of W + 1.
- R6: An initial-count write restarts the countdown. In the next cycle the current count equals the written value, and the prescaler phase restarts from that write.
- R7: An initial count of zero never produces an expiry, in either mode.
- R8: While entry bit 16 (mask) is set, expiries raise no request, and the count still advances.
- R9: Each unmasked expiry raises irq_req for exactly one cycle, in the cycle after the expiring tick edge, with irq_vector equal to entry bits 7:0.
- R10: The timer entry reads back bit 17 (mode), bit 16 (mask) and bits 7:0 (vector) as written, and all its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 divide, 1 timer entry, 2 initial count, 3 current count (read only) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register (combinational) |
| irq_req | output | 1 | One-cycle timer interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The timer is run with one-shot loads at the fastest divide and at divide by 16. These separate the hold at zero and the single expiry from any reload behaviour, and they check the split divide code. Periodic loads at divide by 2 and divide by 32 show whether a period is W + 1 ticks or W ticks. A reload issued in the middle of a period shows whether the prescaler phase restarts. Masked running and zero initial counts in both modes separate the count from the request path. Throughout, the current count and the request are compared every cycle against a closed-form model of elapsed ticks.

// File: rtl/lct_pkg.sv
package lct_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned SHIFT_W = 3;
  localparam int unsigned DIV_W   = 4;

  typedef enum logic [1:0] {
    SEL_DIVIDE  = 2'd0,
    SEL_ENTRY   = 2'd1,
    SEL_INITIAL = 2'd2,
    SEL_CURRENT = 2'd3
  } reg_sel_e;

  // bits of the timer entry the block uses
  localparam int unsigned ENTRY_PERIODIC_BIT = 17;
  localparam int unsigned ENTRY_MASK_BIT     = 16;

  // keep bits 3,1,0 of a divide write
  function automatic logic [DIV_W-1:0] divide_keep(input logic [DIV_W-1:0] raw);
    divide_keep = raw & 4'b1011;
  endfunction

  // shift = ({b3,b1,b0} + 1) mod 8
  function automatic logic [SHIFT_W-1:0] divide_shift(input logic [DIV_W-1:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    divide_shift = code + 3'd1;
  endfunction

endpackage

// File: rtl/lct_regs.sv
module lct_regs
  import lct_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [CNT_W-1:0]   wdata,
  output logic [DIV_W-1:0]   divide_q,
  output logic [SHIFT_W-1:0] shift,
  output logic               entry_periodic,
  output logic               entry_mask,
  output logic [VEC_W-1:0]   entry_vector,
  output logic [CNT_W-1:0]   initial_q,
  output logic               load_pulse
);

  logic [DIV_W-1:0] divide_d;
  logic             periodic_d, mask_d;
  logic [VEC_W-1:0] vector_d;
  logic [CNT_W-1:0] initial_d;
  logic             wr_div, wr_entry, wr_init;

  always_comb begin
    wr_div   = wr_en && (addr == SEL_DIVIDE);
    wr_entry = wr_en && (addr == SEL_ENTRY);
    wr_init  = wr_en && (addr == SEL_INITIAL);
  end

  always_comb begin
    divide_d   = divide_q;
    periodic_d = entry_periodic;
    mask_d     = entry_mask;
    vector_d   = entry_vector;
    initial_d  = initial_q;
    if (wr_div) begin
      divide_d = divide_keep(wdata[DIV_W-1:0]);
    end
    if (wr_entry) begin
      periodic_d = wdata[ENTRY_PERIODIC_BIT];
      mask_d     = wdata[ENTRY_MASK_BIT];
      vector_d   = wdata[VEC_W-1:0];
    end
    if (wr_init) begin
      initial_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divide_q       <= '0;
      entry_periodic <= 1'b0;
      entry_mask     <= 1'b1;
      entry_vector   <= '0;
      initial_q      <= '0;
    end else begin
      if (wr_div) begin
        divide_q <= divide_d;
      end
      if (wr_entry) begin
        entry_periodic <= periodic_d;
        entry_mask     <= mask_d;
        entry_vector   <= vector_d;
      end
      if (wr_init) begin
        initial_q <= initial_d;
      end
    end
  end

  assign shift      = divide_shift(divide_q);
  assign load_pulse = wr_init;

endmodule

// File: rtl/lct_prescaler.sv
module lct_prescaler
  import lct_pkg::*;
#(
  parameter int unsigned SHW = SHIFT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic [SHW-1:0] shift,
  output logic           tick
);

  localparam int unsigned PW = (1 << SHW) - 1;

  logic [PW-1:0] phase_q, phase_d;
  logic [PW-1:0] low_mask;

  always_comb begin
    low_mask = (PW'(1) << shift) - PW'(1);
    tick     = &(phase_q | ~low_mask);
  end

  always_comb begin
    if (restart) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/lct_downcount.sv
module lct_downcount #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);

  logic [CNT_W-1:0] count_d;
  logic             armed_q, armed_d;
  logic             at_zero;

  assign at_zero = (count_q == '0);

  always_comb begin
    count_d = count_q;
    armed_d = armed_q;
    expire  = 1'b0;
    if (load) begin
      count_d = load_val;
      armed_d = |load_val;
    end else if (tick) begin
      if (!at_zero) begin
        count_d = count_q - CNT_W'(1);
      end else if (armed_q) begin
        expire = 1'b1;
        if (periodic) begin
          count_d = reload_val;
        end else begin
          armed_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else begin
      count_q <= count_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/lvt_countdown_timer.sv
module lvt_countdown_timer
  import lct_pkg::*;
#(
  parameter int unsigned CNT_W = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector
);

  logic [DIV_W-1:0]   divide_q;
  logic [SHIFT_W-1:0] shift;
  logic               lvt_periodic, lvt_mask;
  logic [VEC_W-1:0]   lvt_vector;
  logic [CNT_W-1:0]   init_q, cur_q;
  logic               load_pulse, tick, expire;
  logic               irq_d;
  logic [VEC_W-1:0]   vec_d;

  lct_regs #(.CNT_W(CNT_W)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .addr           (addr),
    .wdata          (wdata),
    .divide_q       (divide_q),
    .shift          (shift),
    .entry_periodic (lvt_periodic),
    .entry_mask     (lvt_mask),
    .entry_vector   (lvt_vector),
    .initial_q      (init_q),
    .load_pulse     (load_pulse)
  );

  lct_prescaler #(.SHW(SHIFT_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load_pulse),
    .shift   (shift),
    .tick    (tick)
  );

  lct_downcount #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_pulse),
    .load_val   (wdata),
    .reload_val (init_q),
    .tick       (tick),
    .periodic   (lvt_periodic),
    .count_q    (cur_q),
    .expire     (expire)
  );

  always_comb begin
    irq_d = expire && !lvt_mask;
    vec_d = irq_d ? lvt_vector : irq_vector;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req    <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_req    <= irq_d;
      irq_vector <= vec_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (reg_sel_e'(addr))
      SEL_DIVIDE:  rdata[DIV_W-1:0] = divide_q;
      SEL_ENTRY: begin
        rdata[ENTRY_PERIODIC_BIT] = lvt_periodic;
        rdata[ENTRY_MASK_BIT]     = lvt_mask;
        rdata[VEC_W-1:0]          = lvt_vector;
      end
      SEL_INITIAL: rdata = init_q;
      SEL_CURRENT: rdata = cur_q;
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/lvt_timer_chk.sv
module lvt_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic             irq_req,
  input logic [CNT_W-1:0] cur_count,
  input logic [CNT_W-1:0] init_count,
  input logic             lvt_mask
);

  logic init_wr;
  assign init_wr = wr_en && (addr == 2'd2);

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  assert_irq_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(lvt_mask));

  assert_load_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (cur_count == $past(wdata)));

  assert_no_zero_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (init_count != '0));

  // R3 / R5: without a load the count only falls, or reloads to the initial value
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_wr |=> ((cur_count <= $past(cur_count)) || (cur_count == init_count)));

endmodule

bind lvt_countdown_timer lvt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .irq_req    (irq_req),
  .cur_count  (cur_q),
  .init_count (init_q),
  .lvt_mask   (lvt_mask)
);

// File: tb/tb_lvt_countdown_timer.sv
module tb_lvt_countdown_timer;

  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  logic        clk, rst_n, wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq_req;
  logic [7:0]  irq_vector;

  int total = 0, bad = 0;
  int irq_cnt = 0;
  logic [7:0] last_vec = '0;
  bit cmp_on = 0;
  string phase = "R1";

  // reference model state
  bit   m_loaded, m_mask, m_per, exp_irq;
  int   m_n, m_w, m_shift, exp_cur;
  logic [7:0] m_vec, exp_vec;

  lvt_countdown_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_req(irq_req), .irq_vector(irq_vector)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // closed-form model of elapsed ticks since load
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_loaded = 0; m_mask = 1; m_per = 0; m_n = 0; m_w = 0; m_shift = 1;
      m_vec = 0; exp_irq = 0; exp_cur = 0; exp_vec = 0;
    end else begin
      int nn, d;
      bit fire;
      nn = m_n + 1;
      fire = 0;
      if (m_loaded && m_w > 0 && (nn % (1 << m_shift)) == 0) begin
        d = nn >> m_shift;
        if (m_per ? ((d % (m_w + 1)) == 0) : (d == m_w + 1)) fire = !m_mask;
      end
      if (fire) exp_vec = m_vec;
      if (wr_en && addr == 2'd2) begin
        m_loaded = 1; m_n = 0; m_w = int'(wdata); fire = 0;
      end else begin
        m_n = nn;
      end
      if (wr_en && addr == 2'd1) begin
        m_vec = wdata[7:0]; m_mask = wdata[16]; m_per = wdata[17];
      end
      if (wr_en && addr == 2'd0)
        m_shift = (int'({wdata[3], wdata[1:0]}) + 1) % 8;
      exp_irq = fire;
      if (!m_loaded) exp_cur = 0;
      else begin
        d = m_n >> m_shift;
        if (m_per) exp_cur = m_w - (d % (m_w + 1));
        else exp_cur = (d >= m_w) ? 0 : m_w - d;
      end
    end
  end

  // every-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_req) begin irq_cnt++; last_vec = irq_vector; end
      if (cmp_on) begin
        check(phase, irq_req, exp_irq, "irq_req");
        if (exp_irq) check("R9", irq_vector, exp_vec, "irq_vector");
        if (addr == 2'd3 && !wr_en) check(phase, rdata, exp_cur, "current count");
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #Q;
    wr_en = 1; addr = a; wdata = d;
    if (a == 2'd2) irq_cnt = 0;
    @(posedge clk); #Q;
    wr_en = 0; addr = 2'd3; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(posedge clk); #Q;
    addr = a;
    @(negedge clk);
    v = rdata;
    @(posedge clk); #Q;
    addr = 2'd3;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req, input string what);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp, what);
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic load(input logic [31:0] div, input logic [31:0] entry, input logic [31:0] init);
    cmp_on = 0;
    wr(2'd0, div);
    wr(2'd1, entry);
    wr(2'd2, init);
    cmp_on = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    rst_n = 0; wr_en = 0; addr = 2'd3; wdata = '0;
    run(3); #Q; rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", irq_req, 0, "irq_req after reset");
    check("R1", irq_vector, 0, "irq_vector after reset");
    rd_chk(2'd0, 32'h0, "R1", "divide reset");
    rd_chk(2'd1, 32'h0001_0000, "R1", "entry reset");
    rd_chk(2'd2, 32'h0, "R1", "initial reset");
    rd_chk(2'd3, 32'h0, "R1", "current reset");

    // R3 R4 one-shot, divide by 1 via 0xF masked to 0xB
    phase = "R3";
    load(32'hFFFF_FFFF & 32'hF, 32'hFFFC_0041 & 32'h0000_00FF | 32'h41, 32'd5);
    run(20);
    check("R4", irq_cnt, 1, "one-shot expiry count");
    rd_chk(2'd0, 32'hB, "R2", "divide masked readback");
    rd_chk(2'd1, 32'h0000_0041, "R10", "entry one-shot readback");

    // R5 periodic, divide by 2
    phase = "R5";
    load(32'h0, 32'hFFF2_0052 & 32'h0002_00FF, 32'd3);
    run(35);
    check("R5", irq_cnt, 4, "periodic expiry count");
    check("R9", last_vec, 8'h52, "periodic vector");

    // R6 restart mid-period
    phase = "R6";
    wr(2'd2, 32'd6);
    rd_chk(2'd3, 32'd6, "R6", "count right after reload");
    run(30);
    check("R6", irq_cnt, 2, "expiries after restart");
    rd_chk(2'd1, 32'h0002_0052, "R10", "entry periodic readback");

    // R8 masked running
    phase = "R8";
    wr(2'd1, 32'h0003_0052);
    irq_cnt = 0;
    rd(2'd3, a);
    run(4);
    rd(2'd3, b);
    check("R8", (a != b), 1, "count advances while masked");
    run(36);
    check("R8", irq_cnt, 0, "no request while masked");
    rd_chk(2'd1, 32'h0003_0052, "R10", "entry masked readback");

    // R7 zero initial count
    phase = "R7";
    load(32'h0, 32'h0002_0052, 32'd0);
    run(30);
    check("R7", irq_cnt, 0, "periodic zero never fires");
    load(32'h0, 32'h0000_0052, 32'd0);
    run(20);
    check("R7", irq_cnt, 0, "one-shot zero never fires");

    // R2 divide by 16 (code 3) one-shot, divide by 32 (code 4) periodic
    phase = "R2";
    load(32'h3, 32'h0000_0077, 32'd2);
    run(60);
    check("R2", irq_cnt, 1, "one-shot at divide by 16");
    rd_chk(2'd0, 32'h3, "R2", "divide code 3 readback");
    load(32'h8, 32'h0002_009C, 32'd1);
    run(140);
    check("R2", irq_cnt, 2, "periodic at divide by 32");
    check("R9", last_vec, 8'h9C, "last vector");

    cmp_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule